// File: doc/BRIEF.md
# Adaptive Rice Coding Option Selector

This block picks, for each block of J mapped (non-negative) preprocessed samples, the entropy coding option that gives the shortest encoded block. Samples arrive one per clock on a valid/ready input. Every candidate's total encoded length is accumulated in parallel as the samples go by. The candidates are the fundamental sequence, every k-split option, the second extension, the zero-block and raw (uncompressed) output. Each total includes the option identifier bits. One cycle after the last sample, the block computes the winner. In the cycle after that, it presents the winning option index and its bit cost for one cycle.

A bit packer downstream uses the result to emit the codewords. Packing is outside this block. The sample resolution n, the block length J, a reference-sample flag and an option enable mask come with each block. They are captured together with the block's first sample.

Top module: `rice_opt_select`

## Requirements
- R1: A sample is taken on every clock where in_valid and in_ready are both high. After the J-th sample of a block, in_ready is low for exactly one cycle. out_valid is high for exactly one cycle, the cycle after that one, and is low otherwise.
- R2: Option 0 is the fundamental sequence. Its cost is the identifier length plus the sum of (d+1) over the coded samples.
- R3: Option k, for k = 1 to 29, is the k-split option. Its cost is the identifier length plus the sum of ((d>>k)+1+k) over the coded samples.
- R4: Option 30 is the second extension. Samples are paired in arrival order as (a,b). Its cost is the identifier length plus 1, plus the sum over pairs of (γ+1), where γ = (a+b)(a+b+1)/2 + b.
- R5: Option 31 is the zero-block. Its cost is the identifier length plus 2. It can win only when every coded sample of the block is zero.
- R6: Option 32 is raw output. Its cost is the identifier length plus n·J. It is always a candidate, whatever the mask says.
- R7: The identifier length is 4 bits when n ≤ 16 and 5 bits when n > 16.
- R8: The reported option is the candidate with the lowest cost. A tie goes to the lowest option index. out_cost carries that option's cost.
- R9: Bit i of cfg_opt_en, for i = 0 to 31, enables option i. A disabled option is never reported.
- R10: When cfg_ref is high with the first sample, that sample is not coded. It adds n to every option's cost. It is left out of the per-sample terms and out of the zero test. It counts as a = 0 in the first pair of the second extension.
- R11: Bits of in_data at position n and above are ignored.
- R12: cfg_n, cfg_j, cfg_ref and cfg_opt_en are used only as they stand with a block's first sample. Changes later in the block have no effect. J must be even, from 2 to 64.
- R13: While reset is held, in_ready is 1, out_valid is 0, and out_opt and out_cost are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_n | input | 6 | Sample resolution n, 1 to 32 |
| cfg_j | input | 7 | Block length J, even, 2 to 64 |
| cfg_ref | input | 1 | First sample of this block is a reference sample |
| cfg_opt_en | input | 33 | Per-option enable mask (bit 32 unused) |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block accepts a sample |
| in_data | input | 32 | Mapped sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_opt | output | 6 | Winning option index |
| out_cost | output | 40 | Winning option's total bits |

## Verification
A wrong accumulator or pairing register first becomes visible at the ports in the out_cost of the block that is in flight. When it changes the winner, out_opt shows it as well. That happens two cycles after the block's last sample, so each block is scored against a model within J+2 cycles. A position counter that drifts shows up at once as in_ready falling on the wrong cycle, or out_valid firing early or late. Stale configuration or a stale zero flag only shows up in later blocks. The stimulus therefore runs blocks back to back, with gaps, and with configuration churn in the middle of a block.

// File: rtl/rice_sel_pkg.sv
package rice_sel_pkg;

   typedef enum logic {
      ST_RUN   = 1'b0,
      ST_FLUSH = 1'b1
   } sel_state_e;

   // identifier field length for a given sample resolution
   function automatic logic [2:0] id_len(input int n);
      return (n <= 16) ? 3'd4 : 3'd5;
   endfunction

endpackage

// File: rtl/rice_sel_split.sv
module rice_sel_split #(
   parameter int SMP_W  = 32,
   parameter int K_MAX  = 29,
   parameter int COST_W = 40,
   parameter int NW     = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr,
   input  logic                          en,
   input  logic                          is_ref,
   input  logic [NW-1:0]                 n,
   input  logic [SMP_W-1:0]              d,
   output logic [K_MAX:0][COST_W-1:0]    acc
);

   // k = 0 is the fundamental sequence, k >= 1 the split options
   for (genvar g = 0; g <= K_MAX; g++) begin : g_k
      logic [COST_W-1:0] term;
      assign term = is_ref ? COST_W'(n) : (COST_W'(d >> g) + COST_W'(g + 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      acc[g] <= '0;
         else if (clr)    acc[g] <= '0;
         else if (en)     acc[g] <= acc[g] + term;
      end
   end

   // R2: every accepted sample adds at least one bit to the sequence total
   a_r2_fs_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && n != '0) |=> acc[0] > $past(acc[0]));

endmodule

// File: rtl/rice_sel_se.sv
module rice_sel_se #(
   parameter int SMP_W  = 32,
   parameter int COST_W = 40,
   parameter int NW     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic              is_ref,
   input  logic              odd,
   input  logic [NW-1:0]     n,
   input  logic [SMP_W-1:0]  d,
   input  logic [2:0]        low_id,
   output logic [COST_W-1:0] cost_o
);

   localparam int GW = 2 * SMP_W + 3;

   logic [SMP_W-1:0]  held;
   logic [COST_W-1:0] acc;
   logic [SMP_W:0]    s;
   logic [SMP_W+1:0]  s_p1;
   logic [GW-1:0]     prod;
   logic [GW-1:0]     gamma;
   logic [GW:0]       sum;
   logic [COST_W-1:0] acc_nx;
   logic [COST_W:0]   tot;

   assign s      = {1'b0, held} + {1'b0, d};
   assign s_p1   = {1'b0, s} + 1'b1;
   assign prod   = GW'(s) * GW'(s_p1);
   assign gamma  = (prod >> 1) + GW'(d);
   assign sum    = (GW+1)'(acc) + (GW+1)'(gamma) + (GW+1)'(1);
   assign acc_nx = (sum > (GW+1)'({COST_W{1'b1}})) ? {COST_W{1'b1}} : sum[COST_W-1:0];
   assign tot    = (COST_W+1)'(acc) + (COST_W+1)'(low_id);
   assign cost_o = tot[COST_W] ? {COST_W{1'b1}} : tot[COST_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= '0;
         acc  <= '0;
      end else if (clr) begin
         held <= '0;
         acc  <= '0;
      end else if (en) begin
         if (!odd) begin
            held <= is_ref ? '0 : d;
            if (is_ref) acc <= acc + COST_W'(n);
         end else begin
            acc <= acc_nx;
         end
      end
   end

   // R4: a completed pair never lowers the running total
   a_r4_pair_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (en && odd && !clr) |=> acc >= $past(acc));

endmodule

// File: rtl/rice_sel_pick.sv
module rice_sel_pick #(
   parameter int NUM_OPT = 33,
   parameter int COST_W  = 40,
   parameter int IDX_W   = 6
) (
   input  logic [NUM_OPT-1:0][COST_W-1:0] cost,
   input  logic [NUM_OPT-1:0]             elig,
   output logic [IDX_W-1:0]               idx,
   output logic [COST_W-1:0]              best
);

   // strict compare in ascending order: ties keep the lower index
   always_comb begin
      logic found;
      found = 1'b0;
      best  = {COST_W{1'b1}};
      idx   = IDX_W'(NUM_OPT - 1);
      for (int i = 0; i < NUM_OPT; i++) begin
         if (elig[i] && (!found || cost[i] < best)) begin
            found = 1'b1;
            best  = cost[i];
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/rice_opt_select.sv
module rice_opt_select #(
   parameter int SMP_W = 32,
   parameter int MAX_J = 64,
   parameter int K_MAX = 29
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [$clog2(SMP_W+1)-1:0]    cfg_n,
   input  logic [$clog2(MAX_J+1)-1:0]    cfg_j,
   input  logic                          cfg_ref,
   input  logic [K_MAX+3:0]              cfg_opt_en,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [SMP_W-1:0]              in_data,
   output logic                          out_valid,
   output logic [$clog2(K_MAX+4)-1:0]    out_opt,
   output logic [SMP_W+$clog2(MAX_J+1):0] out_cost
);
   import rice_sel_pkg::*;

   localparam int NUM_OPT = K_MAX + 4;
   localparam int IDX_W   = $clog2(NUM_OPT);
   localparam int NW      = $clog2(SMP_W + 1);
   localparam int JW      = $clog2(MAX_J + 1);
   localparam int COST_W  = SMP_W + JW + 1;
   localparam int OPT_SE  = K_MAX + 1;
   localparam int OPT_ZB  = K_MAX + 2;
   localparam int OPT_NC  = K_MAX + 3;

   if (SMP_W < 2) begin : g_bad_w
      $error("SMP_W must be at least 2");
   end
   if (MAX_J < 2 || (MAX_J % 2) != 0) begin : g_bad_j
      $error("MAX_J must be even and at least 2");
   end
   if (K_MAX < 1 || K_MAX > SMP_W - 1) begin : g_bad_k
      $error("K_MAX must lie in 1 .. SMP_W-1");
   end

   sel_state_e            st;
   logic [JW-1:0]         cnt;
   logic [NW-1:0]         n_q;
   logic [JW-1:0]         j_q;
   logic                  ref_q;
   logic [NUM_OPT-1:0]    en_q;
   logic                  all_zero;
   logic [COST_W-1:0]     nc_acc;

   logic                  first, accept, last, is_ref;
   logic [NW-1:0]         cur_n;
   logic [JW-1:0]         cur_j;
   logic [SMP_W-1:0]      smp_mask, d;
   logic [2:0]            id_bits;

   assign in_ready = (st == ST_RUN);
   assign first    = (cnt == '0);
   assign cur_n    = first ? cfg_n : n_q;
   assign cur_j    = first ? cfg_j : j_q;
   assign accept   = in_valid && in_ready;
   assign last     = accept && (cnt == cur_j - 1'b1);
   assign is_ref   = first && cfg_ref;
   assign smp_mask = {SMP_W{1'b1}} >> (SMP_W - int'(cur_n));
   assign d        = in_data & smp_mask;
   assign id_bits  = id_len(int'(n_q));

   logic [K_MAX:0][COST_W-1:0] split_acc;
   logic [COST_W-1:0]          se_cost;

   rice_sel_split #(.SMP_W(SMP_W), .K_MAX(K_MAX), .COST_W(COST_W), .NW(NW)) u_split (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (st == ST_FLUSH),
      .en     (accept),
      .is_ref (is_ref),
      .n      (cur_n),
      .d      (d),
      .acc    (split_acc)
   );

   rice_sel_se #(.SMP_W(SMP_W), .COST_W(COST_W), .NW(NW)) u_se (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (st == ST_FLUSH),
      .en     (accept),
      .is_ref (is_ref),
      .odd    (cnt[0]),
      .n      (cur_n),
      .d      (d),
      .low_id (id_bits + 3'd1),
      .cost_o (se_cost)
   );

   logic [NUM_OPT-1:0][COST_W-1:0] fin;
   logic [NUM_OPT-1:0]             elig;
   logic [IDX_W-1:0]               pick_idx;
   logic [COST_W-1:0]              pick_cost;

   always_comb begin
      for (int k = 0; k <= K_MAX; k++) fin[k] = split_acc[k] + COST_W'(id_bits);
      fin[OPT_SE] = se_cost;
      fin[OPT_ZB] = COST_W'(ref_q ? n_q : '0) + COST_W'(id_bits) + COST_W'(2);
      fin[OPT_NC] = nc_acc + COST_W'(id_bits);
      elig         = en_q;
      elig[OPT_ZB] = en_q[OPT_ZB] & all_zero;
      elig[OPT_NC] = 1'b1;
   end

   rice_sel_pick #(.NUM_OPT(NUM_OPT), .COST_W(COST_W), .IDX_W(IDX_W)) u_pick (
      .cost (fin),
      .elig (elig),
      .idx  (pick_idx),
      .best (pick_cost)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_RUN;
         cnt       <= '0;
         n_q       <= '0;
         j_q       <= '0;
         ref_q     <= 1'b0;
         en_q      <= '0;
         all_zero  <= 1'b1;
         nc_acc    <= '0;
         out_valid <= 1'b0;
         out_opt   <= '0;
         out_cost  <= '0;
      end else begin
         out_valid <= (st == ST_FLUSH);
         if (st == ST_FLUSH) begin
            out_opt  <= pick_idx;
            out_cost <= pick_cost;
            nc_acc   <= '0;
            all_zero <= 1'b1;
            st       <= ST_RUN;
         end else if (accept) begin
            if (first) begin
               n_q   <= cfg_n;
               j_q   <= cfg_j;
               ref_q <= cfg_ref;
               en_q  <= cfg_opt_en;
            end
            nc_acc <= nc_acc + COST_W'(cur_n);
            if (!is_ref && d != '0) all_zero <= 1'b0;
            if (last) begin
               cnt <= '0;
               st  <= ST_FLUSH;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R1: result strobe lasts one cycle
   a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   // R1: input stall lasts one cycle
   a_r1_stall_one: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> in_ready);
   // R12: a block starts with a legal, even length
   a_r12_cfg_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && first) |-> (cfg_j >= 2 && cfg_j <= MAX_J && !cfg_j[0] && cfg_n != '0));
   // R9: the chosen option is always a live candidate
   a_r9_pick_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FLUSH) |-> elig[pick_idx]);
   // R6: the winner never costs more than raw output
   a_r6_nc_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FLUSH) |-> pick_cost <= fin[OPT_NC]);
   // R5: zero-block only wins after an all-zero block
   a_r5_zero_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FLUSH && pick_idx == IDX_W'(OPT_ZB)) |-> all_zero);

endmodule

// File: tb/rice_opt_select_tb.sv
module rice_opt_select_tb;

   localparam int CLK_PERIOD = 10;
   localparam longint MAXC = (64'd1 << 40) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  cfg_n = 6'd8;
   logic [6:0]  cfg_j = 7'd16;
   logic        cfg_ref = 1'b0;
   logic [32:0] cfg_opt_en = '1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        out_valid;
   logic [5:0]  out_opt;
   logic [39:0] out_cost;

   always #(CLK_PERIOD/2) clk = ~clk;

   rice_opt_select u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_n(cfg_n), .cfg_j(cfg_j), .cfg_ref(cfg_ref),
      .cfg_opt_en(cfg_opt_en), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_opt(out_opt), .out_cost(out_cost)
   );

   int errs = 0;
   int checks = 0;
   string cur_tag = "R8";
   logic [31:0] blk [64];

   // ---------------- behavioural reference ----------------
   bit          m_run = 1'b1;
   int          m_cnt = 0;
   int          m_n, m_j;
   bit          m_ref;
   logic [32:0] m_en;
   string       m_tag;
   longint      mq [64];
   bit          exp_valid = 1'b0;
   int          exp_opt = 0;
   longint      exp_cost = 0;
   string       exp_tag = "";
   bit          chk_on = 1'b0;

   task automatic score(output int idx, output longint best);
      longint c [33];
      bit     el [33];
      int     id = (m_n <= 16) ? 4 : 5;
      longint base = m_ref ? m_n : 0;
      int     st = m_ref ? 1 : 0;
      bit     allz = 1'b1;
      longint se;
      bit     found = 1'b0;
      for (int k = 0; k <= 29; k++) begin
         c[k] = base + id;
         for (int i = st; i < m_j; i++) c[k] += (mq[i] >> k) + 1 + k;
      end
      se = base;
      for (int p = 0; p < m_j; p += 2) begin
         longint a = (p == 0 && m_ref) ? 0 : mq[p];
         longint b = mq[p+1];
         longint s = a + b;
         if (s > (64'd1 << 21)) se = MAXC;
         else begin
            se = se + (s * (s + 1)) / 2 + b + 1;
            if (se > MAXC) se = MAXC;
         end
      end
      se = se + id + 1;
      if (se > MAXC) se = MAXC;
      c[30] = se;
      for (int i = st; i < m_j; i++) if (mq[i] != 0) allz = 1'b0;
      c[31] = base + id + 2;
      c[32] = longint'(m_n) * m_j + id;
      for (int i = 0; i < 33; i++) el[i] = m_en[i];
      el[31] = m_en[31] && allz;
      el[32] = 1'b1;
      idx = 32; best = MAXC;
      for (int i = 0; i < 33; i++)
         if (el[i] && (!found || c[i] < best)) begin
            found = 1'b1; best = c[i]; idx = i;
         end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 1'b1; m_cnt = 0; exp_valid = 1'b0;
      end else begin
         exp_valid = 1'b0;
         if (m_run) begin
            if (in_valid) begin
               if (m_cnt == 0) begin
                  m_n = int'(cfg_n); m_j = int'(cfg_j); m_ref = cfg_ref;
                  m_en = cfg_opt_en; m_tag = cur_tag;
               end
               mq[m_cnt] = longint'(in_data) & ((64'd1 << m_n) - 1);
               m_cnt++;
               if (m_cnt == m_j) m_run = 1'b0;
            end
         end else begin
            score(exp_opt, exp_cost);
            exp_tag = m_tag;
            exp_valid = 1'b1;
            m_run = 1'b1;
            m_cnt = 0;
         end
      end
   end

   // compare away from the active edge
   always @(negedge clk) begin
      if (rst_n && chk_on) begin
         checks++;
         if (in_ready !== m_run) begin
            errs++; $display("FAIL R1 in_ready got %0b exp %0b", in_ready, m_run);
         end
         checks++;
         if (out_valid !== exp_valid) begin
            errs++; $display("FAIL R1 out_valid got %0b exp %0b", out_valid, exp_valid);
         end
         if (exp_valid) begin
            checks++;
            if (int'(out_opt) != exp_opt) begin
               errs++; $display("FAIL %s out_opt got %0d exp %0d", exp_tag, out_opt, exp_opt);
            end
            checks++;
            if (longint'(out_cost) != exp_cost) begin
               errs++; $display("FAIL %s out_cost got %0d exp %0d", exp_tag, out_cost, exp_cost);
            end
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic fill(int mode, int n, int j, bit rf);
      for (int i = 0; i < j; i++) begin
         case (mode)
            0: blk[i] = 0;
            1: blk[i] = $urandom % 2;
            2: blk[i] = $urandom % 8;
            3: blk[i] = $urandom % (1 << (n/2 + 1));
            4: blk[i] = $urandom & ((n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1));
            5: blk[i] = 1 + ($urandom % 2);
            default: blk[i] = $urandom;
         endcase
      end
      if (rf && mode == 0) blk[0] = 32'h5;
   endtask

   task automatic run_block(string tag, int n, int j, bit rf, logic [32:0] en,
                            int mode, bit scramble, bit gaps);
      fill(mode, n, j, rf);
      for (int i = 0; i < j; i++) begin
         @(negedge clk);
         if (gaps && (i % 3 == 1)) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_data  = blk[i];
         if (i == 0) begin
            cfg_n = 6'(n); cfg_j = 7'(j); cfg_ref = rf; cfg_opt_en = en; cur_tag = tag;
         end else if (scramble) begin
            cfg_n = 6'(1 + $urandom % 32);
            cfg_j = 7'(2 * (1 + $urandom % 32));
            cfg_ref = 1'($urandom);
            cfg_opt_en = {1'($urandom), $urandom};
         end
         while (in_ready !== 1'b1) @(negedge clk);
      end
   endtask

   task automatic idle(int c);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (c) @(negedge clk);
   endtask

   task automatic run_all();
      // R13: reset state
      repeat (3) @(negedge clk);
      checks++; if (in_ready !== 1'b1) begin errs++; $display("FAIL R13 in_ready got %0b exp 1", in_ready); end
      checks++; if (out_valid !== 1'b0) begin errs++; $display("FAIL R13 out_valid got %0b exp 0", out_valid); end
      checks++; if (out_opt !== '0) begin errs++; $display("FAIL R13 out_opt got %0d exp 0", out_opt); end
      checks++; if (out_cost !== '0) begin errs++; $display("FAIL R13 out_cost got %0d exp 0", out_cost); end
      rst_n = 1'b1;
      chk_on = 1'b1;
      idle(2);

      run_block("R2",  8, 16, 0, 33'h1, 2, 0, 0);               idle(3);
      run_block("R3", 16, 32, 0, '1, 3, 0, 0);                  idle(3);
      run_block("R9", 16, 16, 0, 33'h20, 3, 0, 0);              idle(3);
      run_block("R4",  8, 16, 0, '1, 1, 0, 0);                  idle(3);
      run_block("R5",  8, 64, 0, '1, 0, 0, 0);                  idle(3);
      run_block("R5",  8, 16, 0, 33'h0_7FFF_FFFF, 0, 0, 0);     idle(3);
      run_block("R5", 12,  8, 1, '1, 0, 0, 0);                  idle(3);
      run_block("R6", 12, 16, 0, '1, 4, 0, 0);                  idle(3);
      run_block("R6",  8, 16, 0, '0, 2, 0, 0);                  idle(3);
      run_block("R7", 17, 16, 0, '1, 3, 0, 0);                  idle(3);
      run_block("R7", 16, 16, 0, '1, 3, 0, 0);                  idle(3);
      run_block("R8",  8, 16, 0, '1, 5, 0, 0);                  idle(3);
      run_block("R8",  8, 16, 0, 33'h6, 5, 0, 0);               idle(3);
      run_block("R9",  8, 16, 0, 33'h4000_0000, 1, 0, 0);       idle(3);
      run_block("R10", 10, 16, 1, '1, 3, 0, 0);                 idle(3);
      run_block("R10",  8, 16, 1, '1, 1, 0, 0);                 idle(3);
      run_block("R11", 10, 16, 0, '1, 6, 0, 0);                 idle(3);
      run_block("R11",  4, 16, 0, '1, 6, 0, 0);                 idle(3);
      run_block("R12", 12, 16, 0, '1, 3, 1, 0);                 idle(3);
      run_block("R12",  8, 32, 1, '1, 1, 1, 1);                 idle(3);
      run_block("R4", 32,  8, 0, 33'h4000_0000, 4, 0, 0);       idle(3);
      // R1: back to back blocks and input gaps
      run_block("R1",  8, 2, 0, '1, 2, 0, 0);
      run_block("R1",  8, 4, 0, '1, 1, 0, 1);
      run_block("R1", 16, 8, 1, '1, 3, 0, 0);
      idle(3);
      for (int t = 0; t < 40; t++) begin
         run_block("R8", 1 + $urandom % 32, 2 * (1 + $urandom % 32), 1'($urandom),
                   {1'b0, $urandom}, $urandom % 7, 1'($urandom), 1'($urandom));
         if (t % 4 == 0) idle(2);
      end
      idle(5);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            errs++; checks++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule